// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers a bank of level-sensitive interrupt request lines from peripherals. It steers each line, under software control, into one of three service classes: fast interrupt, vectored IRQ, or plain (non-vectored) IRQ. It drives one fast-interrupt line and one normal-interrupt line towards a processor core. Every request line first passes through a two-flop synchroniser. After that, a per-line enable mask and a per-line class bit decide where the request goes.

All fast-interrupt sources are OR-merged onto the single fast line. A status word tells the handler which of them are requesting. Normal-interrupt sources can be bound to numbered vector slots, where a lower slot index means higher precedence. Each slot carries its own handler address. Any active IRQ source that no enabled slot claims falls back to one shared default address. Software reads the vector register to fetch and freeze the winning handler address. It writes the same register to end service, and the priority logic then tracks the inputs again.

A small synchronous register bus, with a one-cycle read latency, carries all configuration and status traffic.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the enable mask (read at word 0x04) and the class word (word 0x03) read 0, and both fiq_o and irq_o are low.
- R2: fiq_o is high whenever at least one enabled source whose class bit is 1 is requesting, whatever the normal-interrupt requests are. Several such sources are OR-combined.
- R3: Word 0x01 reads, bit per source, the synchronised requests that are enabled and in the fast class.
- R4: irq_o is high whenever at least one enabled source whose class bit is 0 is requesting. Word 0x00 reads that set bit per source.
- R5: Word 0x02 reads the synchronised request levels regardless of mask and class.
- R6: Writing word 0x04 sets the mask bits written as 1. Writing word 0x05 clears the mask bits written as 1. Bits written as 0 leave the mask unchanged. Word 0x04 reads back the mask.
- R7: Word 0x03 holds one class bit per source: 1 selects the fast class and 0 selects the IRQ class. It reads back what was written.
- R8: Slot k has a control word at 0x10+k (bit 5 enable, bits 4:0 source number) and an address word at 0x20+k. The vector read returns the address of the lowest-index enabled slot whose source is an enabled, requesting, IRQ-class line.
- R9: Word 0x07 holds the default address. The vector read returns it when no enabled slot matches.
- R10: A read of word 0x06 returns the current vector and freezes it. Later reads return the frozen value until any write to 0x06, after which reads follow the inputs again.
- R11: A change on a request input reaches fiq_o and irq_o after exactly the second rising clock edge, not the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_SRC | Peripheral request levels |
| bus_sel_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Word address |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data, valid the cycle after the strobe |
| fiq_o | output | 1 | Fast interrupt to the core |
| irq_o | output | 1 | Normal interrupt to the core |

## Verification
The assertions take for granted that each bus access is a single-cycle strobe and that the request lines are otherwise arbitrary levels. The output properties are therefore stated on the synchronised levels, not on req_i. The stimulus changes requests and issues bus accesses only at falling edges. It holds a request pattern for at least two rising edges before it reads any status or vector. It always closes a frozen vector with a write to 0x06 before it starts the next pattern.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam logic [ADDR_W-1:0] A_IRQ_STAT = 6'h00;
  localparam logic [ADDR_W-1:0] A_FIQ_STAT = 6'h01;
  localparam logic [ADDR_W-1:0] A_RAW      = 6'h02;
  localparam logic [ADDR_W-1:0] A_CLASS    = 6'h03;
  localparam logic [ADDR_W-1:0] A_EN_SET   = 6'h04;
  localparam logic [ADDR_W-1:0] A_EN_CLR   = 6'h05;
  localparam logic [ADDR_W-1:0] A_VEC      = 6'h06;
  localparam logic [ADDR_W-1:0] A_DEF_VEC  = 6'h07;
  localparam logic [ADDR_W-1:0] A_SLOT_CTL = 6'h10;
  localparam logic [ADDR_W-1:0] A_SLOT_VEC = 6'h20;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_SLOT = 16,
  parameter int unsigned DW     = 32,
  parameter int unsigned SRC_W  = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]             irq_act_i,
  input  logic [N_SLOT-1:0]            slot_en_i,
  input  logic [N_SLOT-1:0][SRC_W-1:0] slot_src_i,
  input  logic [N_SLOT-1:0][DW-1:0]    slot_vec_i,
  input  logic [DW-1:0]                def_vec_i,
  output logic [DW-1:0]                vec_o,
  output logic                         hit_any_o
);
  logic [N_SLOT-1:0] hit;

  for (genvar k = 0; k < N_SLOT; k++) begin : g_slot
    assign hit[k] = slot_en_i[k] & irq_act_i[slot_src_i[k]];
  end

  // scan from the lowest precedence up so slot 0 wins last
  always_comb begin
    vec_o = def_vec_i;
    for (int k = N_SLOT - 1; k >= 0; k--) begin
      if (hit[k]) vec_o = slot_vec_i[k];
    end
  end

  assign hit_any_o = |hit;
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_SLOT = 16,
  parameter int unsigned DW     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  req_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic              fiq_o,
  output logic              irq_o
);
  localparam int unsigned SRC_W = $clog2(N_SRC);

  logic [N_SRC-1:0]             req_s, en_q, cls_q, irq_stat, fiq_stat;
  logic [N_SLOT-1:0]            slot_en_q;
  logic [N_SLOT-1:0][SRC_W-1:0] slot_src_q;
  logic [N_SLOT-1:0][DW-1:0]    slot_vec_q;
  logic [DW-1:0]                def_q, held_q, best_vec, rd_val;
  logic                         busy_q, hit_any, wr, rd;

  assign wr = bus_sel_i & bus_we_i;
  assign rd = bus_sel_i & ~bus_we_i;

  irq_sync #(.W(N_SRC)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_i),
    .q_o   (req_s)
  );

  assign irq_stat = req_s & en_q & ~cls_q;
  assign fiq_stat = req_s & en_q & cls_q;
  assign fiq_o    = |fiq_stat;
  assign irq_o    = |irq_stat;

  irq_prio #(.N_SRC(N_SRC), .N_SLOT(N_SLOT), .DW(DW), .SRC_W(SRC_W)) i_prio (
    .irq_act_i (irq_stat),
    .slot_en_i (slot_en_q),
    .slot_src_i(slot_src_q),
    .slot_vec_i(slot_vec_q),
    .def_vec_i (def_q),
    .vec_o     (best_vec),
    .hit_any_o (hit_any)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= '0;
      cls_q      <= '0;
      def_q      <= '0;
      slot_en_q  <= '0;
      slot_src_q <= '0;
      slot_vec_q <= '0;
    end else if (wr) begin
      unique case (bus_addr_i)
        A_CLASS:   cls_q <= bus_wdata_i[N_SRC-1:0];
        A_EN_SET:  en_q  <= en_q | bus_wdata_i[N_SRC-1:0];
        A_EN_CLR:  en_q  <= en_q & ~bus_wdata_i[N_SRC-1:0];
        A_DEF_VEC: def_q <= bus_wdata_i;
        default: begin
          for (int k = 0; k < N_SLOT; k++) begin
            if (bus_addr_i == A_SLOT_CTL + ADDR_W'(k)) begin
              slot_en_q[k]  <= bus_wdata_i[SRC_W];
              slot_src_q[k] <= bus_wdata_i[SRC_W-1:0];
            end
            if (bus_addr_i == A_SLOT_VEC + ADDR_W'(k)) slot_vec_q[k] <= bus_wdata_i;
          end
        end
      endcase
    end
  end

  // vector freeze: a read latches, a write releases
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      held_q <= '0;
    end else if (bus_sel_i && bus_addr_i == A_VEC) begin
      if (bus_we_i) begin
        busy_q <= 1'b0;
      end else if (!busy_q) begin
        busy_q <= 1'b1;
        held_q <= best_vec;
      end
    end
  end

  always_comb begin
    rd_val = '0;
    unique case (bus_addr_i)
      A_IRQ_STAT: rd_val = DW'(irq_stat);
      A_FIQ_STAT: rd_val = DW'(fiq_stat);
      A_RAW:      rd_val = DW'(req_s);
      A_CLASS:    rd_val = DW'(cls_q);
      A_EN_SET:   rd_val = DW'(en_q);
      A_VEC:      rd_val = busy_q ? held_q : best_vec;
      A_DEF_VEC:  rd_val = def_q;
      default: begin
        for (int k = 0; k < N_SLOT; k++) begin
          if (bus_addr_i == A_SLOT_CTL + ADDR_W'(k)) rd_val = DW'({slot_en_q[k], slot_src_q[k]});
          if (bus_addr_i == A_SLOT_VEC + ADDR_W'(k)) rd_val = slot_vec_q[k];
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  bus_rdata_o <= '0;
    else if (rd)  bus_rdata_o <= rd_val;
  end
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk
  import irq_vec_pkg::*;
#(
  parameter int unsigned N_SRC = 32,
  parameter int unsigned DW    = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_SRC-1:0]  req_s,
  input logic [N_SRC-1:0]  en_q,
  input logic [N_SRC-1:0]  cls_q,
  input logic              fiq_o,
  input logic              irq_o,
  input logic              hit_any,
  input logic [DW-1:0]     best_vec,
  input logic [DW-1:0]     def_q,
  input logic              busy_q,
  input logic [DW-1:0]     held_q,
  input logic              bus_sel_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i
);
  logic vec_wr;
  assign vec_wr = bus_sel_i && bus_we_i && bus_addr_i == A_VEC;

  p_fiq_merge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(req_s & en_q & cls_q)) |-> fiq_o);

  p_fiq_needs_class_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o |-> (|(cls_q & en_q)));

  p_irq_raise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(req_s & en_q & ~cls_q)) |-> irq_o);

  p_irq_needs_class_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|(en_q & ~cls_q)));

  p_default_on_miss_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_any |-> best_vec == def_q);

  p_hold_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !vec_wr) |=> (busy_q && $stable(held_q)));

  p_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_wr |=> !busy_q);
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.N_SRC(N_SRC), .DW(DW)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_s     (req_s),
  .en_q      (en_q),
  .cls_q     (cls_q),
  .fiq_o     (fiq_o),
  .irq_o     (irq_o),
  .hit_any   (hit_any),
  .best_vec  (best_vec),
  .def_q     (def_q),
  .busy_q    (busy_q),
  .held_q    (held_q),
  .bus_sel_i (bus_sel_i),
  .bus_we_i  (bus_we_i),
  .bus_addr_i(bus_addr_i)
);

// File: tb/test_irq_vec_ctrl.sv
`timescale 1ns/1ps
module test_irq_vec_ctrl;
  localparam int NS = 32;
  localparam int NK = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] req = '0;
  logic        sel = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        fiq, irq;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  irq_vec_ctrl i_irq_vec_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .fiq_o(fiq), .irq_o(irq)
  );

  function automatic int src_of(int k);
    return (k * 7 + 3) % NS;
  endfunction
  function automatic logic [31:0] vec_of(int k);
    return 32'h0000_1000 + 32'(k) * 32'h40;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    sel = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    d = rdata;
    sel = 1'b0;
  endtask

  task automatic settle(logic [31:0] r);
    req = r;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, bit_i, unclaimed;
    int free_src;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 fiq_o", 32'(fiq), 0);
    chk("R1 irq_o", 32'(irq), 0);
    rd(6'h04, d); chk("R1 mask", d, 0);
    rd(6'h03, d); chk("R1 class", d, 0);

    // R6 set/clear mask
    wr(6'h04, 32'h0000_00F0); rd(6'h04, d); chk("R6 set", d, 32'h0000_00F0);
    wr(6'h04, 32'h0000_000F); rd(6'h04, d); chk("R6 set or", d, 32'h0000_00FF);
    wr(6'h05, 32'h0000_003C); rd(6'h04, d); chk("R6 clr", d, 32'h0000_00C3);
    wr(6'h05, 32'h0);         rd(6'h04, d); chk("R6 clr zero", d, 32'h0000_00C3);
    wr(6'h04, 32'hFFFF_FFFF);

    // per-source sweep, both classes
    for (int i = 0; i < NS; i++) begin
      for (int c = 0; c < 2; c++) begin
        bit_i = 32'h1 << i;
        wr(6'h03, c ? bit_i : 32'h0);
        rd(6'h03, d); chk("R7 class readback", d, c ? bit_i : 32'h0);
        req = bit_i;
        @(negedge clk);
        chk("R11 fiq one edge", 32'(fiq), 0);
        chk("R11 irq one edge", 32'(irq), 0);
        @(negedge clk);
        chk("R2 fiq", 32'(fiq), 32'(c));
        chk("R4 irq", 32'(irq), 32'(1 - c));
        rd(6'h01, d); chk("R3 fiq stat", d, c ? bit_i : 32'h0);
        rd(6'h00, d); chk("R4 irq stat", d, c ? 32'h0 : bit_i);
        rd(6'h02, d); chk("R5 raw", d, bit_i);
        settle(32'hFFFF_FFFF);
        chk("R2 fiq with irq busy", 32'(fiq), 32'(c));
        rd(6'h01, d); chk("R3 fiq stat all", d, c ? bit_i : 32'h0);
        settle(32'h0);
      end
    end

    // R2 OR-merge with mask interplay
    wr(6'h03, 32'h0000_F0F0);
    settle(32'h0000_0100); chk("R2 irq-class only fiq", 32'(fiq), 0);
    settle(32'h0000_1010); chk("R2 merged fiq", 32'(fiq), 1);
    rd(6'h01, d); chk("R3 two fiq bits", d, 32'h0000_1010);
    wr(6'h05, 32'h0000_1010);
    @(negedge clk);
    chk("R6 masked fiq", 32'(fiq), 0);
    rd(6'h02, d); chk("R5 raw unmasked", d, 32'h0000_1010);
    settle(32'h0000_0001); wr(6'h05, 32'h1);
    chk("R4 masked irq", 32'(irq), 0);
    rd(6'h00, d); chk("R4 masked stat", d, 0);
    wr(6'h04, 32'hFFFF_FFFF); wr(6'h03, 32'h0); settle(32'h0);

    // slot programming
    unclaimed = 32'hFFFF_FFFF;
    for (int k = 0; k < NK; k++) begin
      wr(6'h10 + 6'(k), 32'h20 | 32'(src_of(k)));
      wr(6'h20 + 6'(k), vec_of(k));
      unclaimed &= ~(32'h1 << src_of(k));
    end
    wr(6'h07, 32'hDEAD_0000);
    rd(6'h15, d); chk("R8 ctl readback", d, 32'h20 | 32'(src_of(5)));
    free_src = 0;
    for (int s = NS - 1; s >= 0; s--) if (unclaimed[s]) free_src = s;

    // R8 all slot pairs
    for (int a = 0; a < NK; a++) begin
      for (int b = a + 1; b < NK; b++) begin
        settle((32'h1 << src_of(a)) | (32'h1 << src_of(b)));
        rd(6'h06, d); chk("R8 pair winner", d, vec_of(a));
        wr(6'h06, 32'h0);
      end
    end

    // R9 default paths
    settle(32'h1 << free_src);
    rd(6'h06, d); chk("R9 unclaimed source", d, 32'hDEAD_0000);
    wr(6'h06, 32'h0);
    wr(6'h10, 32'(src_of(0)));
    settle(32'h1 << src_of(0));
    rd(6'h06, d); chk("R9 disabled slot", d, 32'hDEAD_0000);
    wr(6'h06, 32'h0);
    settle((32'h1 << src_of(0)) | (32'h1 << src_of(5)));
    rd(6'h06, d); chk("R8 skip disabled slot", d, vec_of(5));
    wr(6'h06, 32'h0);
    wr(6'h10, 32'h20 | 32'(src_of(0)));
    wr(6'h03, 32'h1 << src_of(0));
    settle(32'h1 << src_of(0));
    rd(6'h06, d); chk("R8 fiq-class not vectored", d, 32'hDEAD_0000);
    wr(6'h06, 32'h0); wr(6'h03, 32'h0);

    // R10 freeze and release
    settle(32'h1 << src_of(3));
    rd(6'h06, d); chk("R10 first read", d, vec_of(3));
    settle((32'h1 << src_of(3)) | (32'h1 << src_of(1)));
    rd(6'h06, d); chk("R10 frozen", d, vec_of(3));
    wr(6'h06, 32'h1234_5678);
    rd(6'h06, d); chk("R10 after release", d, vec_of(1));
    wr(6'h06, 32'h0);
    settle(32'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule